// File: doc/BRIEF.md
# Phase-Frequency Detector with Power-Down Sequencing and Lock Flag

This block compares two single-cycle event pulses, one from a reference divider and one from a feedback divider. Both arrive synchronously to a fast sampling clock. It turns the arrival order into pump-up and pump-down requests for an external charge pump. Each input pulse sets a lead flag. When both flags are set they are cleared together on the following clock. Coincident inputs therefore still give a one-cycle overlap pulse on both outputs, which keeps the detector free of a dead zone around zero phase error. A slope bit chooses which lead drives "up", so the block works with oscillators whose tuning gain is positive or negative.

The block also drives a high-impedance indication for the pump and passes through a magnitude select (1x or 4x current). It raises a lock flag whenever the pump is idle. A power-down request is sequenced in one of two ways, chosen by a mode bit. In the deferred mode the detector finishes the pump pulse in progress before it powers down. In the immediate mode it powers down on the next clock. While powered down, the detector clears its state and ignores pulses, the pump is held at high impedance and the lock flag reads high.

Top module: `pfd_lock_ctrl`

## Requirements
- R1: During and right after synchronous active-low reset: pump_up=0, pump_dn=0, pump_hiz=1, lock_det=1, and the block is not powered down.
- R2: A 1 on ref_pulse sampled at a clock edge sets a reference-lead flag, and a 1 on fb_pulse sets a feedback-lead flag. The flags are visible right after that edge. With vco_pos_slope=1, pump_up equals the reference-lead flag and pump_dn equals the feedback-lead flag.
- R3: With vco_pos_slope=0 the mapping is swapped: pump_up follows the feedback-lead flag and pump_dn follows the reference-lead flag. The slope bit acts combinationally.
- R4: At an edge where both lead flags are already set, both are cleared and any pulse sampled at that edge is dropped. Pulses arriving at the same edge from an idle state give exactly one cycle with pump_up=pump_dn=1.
- R5: pump_hiz is 1 exactly when neither pump_up nor pump_dn is 1.
- R6: lock_det is 1 when both lead flags are clear or the block is powered down, and 0 otherwise.
- R7: cur_4x_out equals cur_4x_in at all times (1 selects 4x magnitude, 0 selects 1x, a quarter of 4x).
- R8: With tri_mode=1, pwr_down=1 sampled at an edge powers the block down at that edge, whatever pump pulse is in progress. From then on pump_up=pump_dn=0, pump_hiz=1.
- R9: With tri_mode=0, pwr_down=1 powers the block down only at the first edge where both lead flags are clear. Until then the pump pulse in progress continues and can be completed by the other input.
- R10: While powered down, the lead flags are cleared on the next edge and pulses are ignored. The block stays powered down while pwr_down=1, even if tri_mode changes. pwr_down=0 sampled at an edge powers the block up at that edge, with both flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_pulse | input | 1 | Single-cycle reference divider event |
| fb_pulse | input | 1 | Single-cycle feedback divider event |
| vco_pos_slope | input | 1 | 1: reference lead drives pump_up; 0: swapped |
| tri_mode | input | 1 | 1: immediate power-down; 0: deferred until pump idle |
| cur_4x_in | input | 1 | Pump magnitude request (1 = 4x) |
| pwr_down | input | 1 | Power-down request |
| pump_up | output | 1 | Pump-up request |
| pump_dn | output | 1 | Pump-down request |
| pump_hiz | output | 1 | Pump output not driven |
| cur_4x_out | output | 1 | Pump magnitude select to the charge pump |
| lock_det | output | 1 | High while the pump is idle or the block is powered down |

## Verification
The block has no parameters, so the bench builds it in its single configuration and drives the whole input space directly. Directed sequences cover coincident pulses and pulses that land in the clearing cycle. They also cover a slope flip in the middle of a pulse, a deferred power-down that has to wait for the completing edge, an immediate power-down that cuts a pulse short, and pulses during power-down. A seeded random phase then mixes all six inputs so that power-down and mode changes overlap pump activity in orders the directed part does not reach.

// File: rtl/pfd_pkg.sv
// Package: shared types for the phase-frequency detector.
// Assumes nothing beyond a single clock domain.
package pfd_pkg;
    // Pair of lead flags held by the detector core.
    typedef struct packed {
        logic ref_lead;
        logic fb_lead;
    } lead_t;
endpackage

// File: rtl/pfd_lead_core.sv
// Module: lead flag pair of the detector.
// Each single-cycle input pulse sets its flag. Both flags clear one clock
// after both are set, and they clear whenever the block is powered down.
// Assumes the inputs are synchronous single-cycle pulses.
module pfd_lead_core
    import pfd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ref_pulse,
    input  logic  fb_pulse,
    input  logic  pd_active,
    output lead_t lead
);

    // Update the lead flags: power-down and the both-set case clear them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lead <= '0;
        end else if (pd_active || (lead.ref_lead && lead.fb_lead)) begin
            lead <= '0;
        end else begin
            lead.ref_lead <= lead.ref_lead | ref_pulse;
            lead.fb_lead  <= lead.fb_lead  | fb_pulse;
        end
    end

    AST_CLEAR_AFTER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (lead.ref_lead && lead.fb_lead) |=> (!lead.ref_lead && !lead.fb_lead)); // R4

    AST_IDLE_WHEN_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        pd_active |=> (!lead.ref_lead && !lead.fb_lead)); // R10

endmodule

// File: rtl/pfd_pwr_seq.sv
// Module: power-down sequencer.
// In immediate mode the request takes effect at the next edge. In deferred
// mode it waits for an edge where the pump is idle. Release is immediate.
// Assumes the busy input reflects the registered lead flags.
module pfd_pwr_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down,
    input  logic tri_mode,
    input  logic busy,
    output logic pd_active
);

    logic pd_next;

    // Decide the powered-down state for the next cycle.
    always_comb begin
        if (!pwr_down)      pd_next = 1'b0;
        else if (pd_active) pd_next = 1'b1;
        else if (tri_mode)  pd_next = 1'b1;
        else                pd_next = !busy;
    end

    // Hold the powered-down state.
    always_ff @(posedge clk) begin
        if (!rst_n) pd_active <= 1'b0;
        else        pd_active <= pd_next;
    end

    AST_ASYNC_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down && tri_mode) |=> pd_active); // R8

    AST_SYNC_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down && !tri_mode && busy && !pd_active) |=> !pd_active); // R9

    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_down |=> !pd_active); // R10

endmodule

// File: rtl/pfd_out_map.sv
// Module: output mapping.
// Applies the slope polarity, gates the pump requests during power-down,
// and derives the high-impedance indication and the lock flag.
// Purely combinational.
module pfd_out_map
    import pfd_pkg::*;
(
    input  lead_t lead,
    input  logic  pd_active,
    input  logic  pos_slope,
    output logic  up,
    output logic  dn,
    output logic  hiz,
    output logic  lock
);

    // Polarity swap and power-down gating of the pump requests.
    always_comb begin
        up   = !pd_active && (pos_slope ? lead.ref_lead : lead.fb_lead);
        dn   = !pd_active && (pos_slope ? lead.fb_lead  : lead.ref_lead);
        hiz  = !(up || dn);
        lock = pd_active || !(lead.ref_lead || lead.fb_lead);
    end

endmodule

// File: rtl/pfd_lock_ctrl.sv
// Module: top of the phase-frequency detector with lock flag and
// power-down sequencing.
// Assumes ref_pulse and fb_pulse are single-cycle pulses synchronous to clk.
module pfd_lock_ctrl
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_pulse,
    input  logic fb_pulse,
    input  logic vco_pos_slope,
    input  logic tri_mode,
    input  logic cur_4x_in,
    input  logic pwr_down,
    output logic pump_up,
    output logic pump_dn,
    output logic pump_hiz,
    output logic cur_4x_out,
    output logic lock_det
);

    lead_t lead;
    logic  pd_active;
    logic  busy;

    assign busy       = lead.ref_lead | lead.fb_lead;
    assign cur_4x_out = cur_4x_in;

    pfd_lead_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_pulse (ref_pulse),
        .fb_pulse  (fb_pulse),
        .pd_active (pd_active),
        .lead      (lead)
    );

    pfd_pwr_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_down  (pwr_down),
        .tri_mode  (tri_mode),
        .busy      (busy),
        .pd_active (pd_active)
    );

    pfd_out_map u_map (
        .lead      (lead),
        .pd_active (pd_active),
        .pos_slope (vco_pos_slope),
        .up        (pump_up),
        .dn        (pump_dn),
        .hiz       (pump_hiz),
        .lock      (lock_det)
    );

    AST_DOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        pd_active |-> (!pump_up && !pump_dn && pump_hiz && lock_det)); // R8

    AST_HIZ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        pump_hiz == !(pump_up || pump_dn)); // R5

endmodule

// File: tb/test_pfd_lock_ctrl.sv
module test_pfd_lock_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_pulse = 1'b0, fb_pulse = 1'b0, vco_pos_slope = 1'b1;
    logic tri_mode = 1'b0, cur_4x_in = 1'b0, pwr_down = 1'b0;
    logic pump_up, pump_dn, pump_hiz, cur_4x_out, lock_det;

    int checks = 0;
    int failures = 0;

    // Behavioural model state
    bit m_ref = 0, m_fb = 0, m_pd = 0;

    always #10 clk = ~clk;

    pfd_lock_ctrl i_pfd_lock_ctrl (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
        .vco_pos_slope(vco_pos_slope), .tri_mode(tri_mode), .cur_4x_in(cur_4x_in),
        .pwr_down(pwr_down), .pump_up(pump_up), .pump_dn(pump_dn),
        .pump_hiz(pump_hiz), .cur_4x_out(cur_4x_out), .lock_det(lock_det)
    );

    // Model update at each edge from the requirements.
    always @(posedge clk) begin
        bit n_ref, n_fb, n_pd;
        if (!rst_n) begin
            n_ref = 0; n_fb = 0; n_pd = 0;                  // R1
        end else begin
            if (!pwr_down)     n_pd = 0;                     // R10
            else if (m_pd)     n_pd = 1;
            else if (tri_mode) n_pd = 1;                     // R8
            else               n_pd = !(m_ref || m_fb);      // R9
            if (m_pd || (m_ref && m_fb)) begin
                n_ref = 0; n_fb = 0;                         // R4, R10
            end else begin
                n_ref = m_ref | ref_pulse;                   // R2
                n_fb  = m_fb  | fb_pulse;
            end
        end
        m_ref = n_ref; m_fb = n_fb; m_pd = n_pd;
    end

    task automatic chk(string tag, string name, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, name, act, exp, $time);
        end
    endtask

    // Drive one cycle of inputs at the falling edge, then compare all outputs.
    task automatic step(logic r, logic f, logic pol, logic tm, logic c4, logic pd, string tag);
        logic e_up, e_dn;
        @(negedge clk);
        ref_pulse = r; fb_pulse = f; vco_pos_slope = pol;
        tri_mode = tm; cur_4x_in = c4; pwr_down = pd;
        #1;
        e_up = !m_pd && (pol ? m_ref : m_fb);                // R3 swap
        e_dn = !m_pd && (pol ? m_fb : m_ref);
        chk(tag, "pump_up", pump_up, e_up);
        chk(tag, "pump_dn", pump_dn, e_dn);
        chk(tag, "pump_hiz", pump_hiz, !(e_up || e_dn));     // R5
        chk(tag, "lock_det", lock_det, m_pd || !(m_ref || m_fb)); // R6
        chk(tag, "cur_4x_out", cur_4x_out, c4);              // R7
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) step(0, 0, 1, 0, 0, 0, "R1");
        @(negedge clk); rst_n = 1'b1;
        step(0, 0, 1, 0, 0, 0, "R1");
        chk("R1", "pump_hiz_after_reset", pump_hiz, 1'b1);
        chk("R1", "lock_after_reset", lock_det, 1'b1);

        // R2: reference leads, then feedback leads, positive slope
        step(1, 0, 1, 0, 0, 0, "R2");
        repeat (3) step(0, 0, 1, 0, 0, 0, "R2");
        chk("R2", "pump_up_held", pump_up, 1'b1);
        step(0, 1, 1, 0, 0, 0, "R2");
        repeat (2) step(0, 0, 1, 0, 0, 0, "R2");
        step(0, 1, 1, 0, 1, 0, "R2");
        repeat (2) step(0, 0, 1, 0, 1, 0, "R2");
        chk("R2", "pump_dn_held", pump_dn, 1'b1);
        step(1, 0, 1, 0, 1, 0, "R2");
        step(0, 0, 1, 0, 0, 0, "R7");

        // R4: coincident pulses and a pulse in the clearing cycle
        step(1, 1, 1, 0, 0, 0, "R4");
        step(0, 0, 1, 0, 0, 0, "R4");
        chk("R4", "overlap_up", pump_up, 1'b1);
        chk("R4", "overlap_dn", pump_dn, 1'b1);
        step(0, 0, 1, 0, 0, 0, "R4");
        step(1, 0, 1, 0, 0, 0, "R4");
        step(0, 1, 1, 0, 0, 0, "R4");
        step(1, 0, 1, 0, 0, 0, "R4");   // lands in the clearing cycle: dropped
        repeat (2) step(0, 0, 1, 0, 0, 0, "R4");
        chk("R4", "dropped_pulse_up", pump_up, 1'b0);

        // R3: negative slope and a slope flip in mid pulse
        step(1, 0, 0, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 0, 0, "R3");
        chk("R3", "swapped_dn", pump_dn, 1'b1);
        step(0, 0, 1, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 0, 0, "R3");
        step(0, 1, 0, 0, 0, 0, "R3");
        repeat (2) step(0, 0, 0, 0, 0, 0, "R3");

        // R9: deferred power-down waits for the completing edge
        step(1, 0, 1, 0, 0, 0, "R9");
        repeat (4) step(0, 0, 1, 0, 0, 1, "R9");
        chk("R9", "still_pumping", pump_up, 1'b1);
        step(0, 1, 1, 0, 0, 1, "R9");
        repeat (3) step(0, 0, 1, 0, 0, 1, "R9");
        chk("R9", "down_hiz", pump_hiz, 1'b1);

        // R10: pulses ignored while down, mode change keeps it down, release
        step(1, 0, 1, 1, 0, 1, "R10");
        step(0, 1, 1, 0, 0, 1, "R10");
        step(1, 1, 1, 0, 1, 1, "R10");
        step(0, 0, 1, 0, 0, 1, "R10");
        chk("R10", "ignored_lock", lock_det, 1'b1);
        step(0, 0, 1, 0, 0, 0, "R10");
        step(1, 0, 1, 0, 0, 0, "R10");
        step(0, 0, 1, 0, 0, 0, "R10");
        chk("R10", "active_after_release", pump_up, 1'b1);
        step(0, 1, 1, 0, 0, 0, "R10");
        step(0, 0, 1, 0, 0, 0, "R10");

        // R8: immediate power-down cuts a pulse short
        step(1, 0, 1, 1, 0, 0, "R8");
        step(0, 0, 1, 1, 0, 1, "R8");
        step(0, 0, 1, 1, 0, 1, "R8");
        chk("R8", "cut_short_up", pump_up, 1'b0);
        step(0, 0, 1, 1, 0, 0, "R8");
        repeat (2) step(0, 0, 1, 1, 0, 0, "R8");

        // R5/R6: seeded random mix of all inputs
        for (int i = 0; i < 2000; i++) begin
            logic [5:0] v;
            v = 6'($urandom(i + 7));
            step(v[0] & v[5], v[1] & ~v[5], v[2], v[3], v[4],
                 (v[5] & v[3]) | (v[2] & v[1] & v[0]), "R5");
        end
        repeat (4) step(0, 0, 1, 0, 0, 0, "R6");

        finish_run();
    end

endmodule